// File: doc/BRIEF.md
# Two-Stage Pipelined RV32 Integer Core

This block is a 32-bit RISC-V integer core with a fetch stage and an execute stage. In the first stage it presents the program counter on the instruction port and captures the returned word. It then hands that word and the address it came from to the second stage. In one cycle the second stage decodes the word, reads two source registers, runs the ALU or the multiplier, accesses data memory and writes the result back.

The core supports the base integer register-immediate and register-register operations, signed and unsigned high-word multiplies, the six conditional branches, byte, halfword and word loads and stores, both jumps, and the two upper-immediate instructions. The instruction port is read without a wait state. The data port is a byte-addressed word interface with a four-lane write mask, and reads on it are also combinational. When a branch is taken or a jump executes, the word already fetched behind it is replaced by a no-op, so that word has no architectural effect.

Top module: `rv2_core`

## Requirements
- R1: With no redirect, the fetch address rises by 4 on every clock. The fetched word and its fetch address move into the execute stage on that same edge.
- R2: A taken branch, `jal` or `jalr` in the execute stage replaces the word fetched behind it with the all-zero no-op. Fetch continues at the target, and the target is computed from the execute-stage address.
- R3: A branch that is not taken flushes nothing, so the next sequential instruction executes.
- R4: During reset and after it, fetch starts at address 0 and the execute stage holds the all-zero word. That word writes no register, stores nothing and does not redirect.
- R5: The register file has 32 registers. Register 0 always reads zero, and writes to it are dropped.
- R6: Opcode 0x13 (register-immediate) selects the operation by funct3: 0 add, 1 shift left, 2 signed set-less-than, 4 xor, 5 shift right, 6 or, 7 and. For funct3 5, instruction bit 30 chooses arithmetic (1) or logical (0).
- R7: Opcode 0x33 (register-register) decodes the same funct3 set. funct7 0x20 selects subtract and arithmetic right shift, and funct7 0x01 selects multiply (funct3 0 low word, 1 signed high word, 3 unsigned high word).
- R8: Opcode 0x63 branches on funct3: 0 equal, 1 not equal, 4 signed less, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal.
- R9: Opcode 0x03 loads (funct3 0 byte, 1 halfword, both sign-extended; 2 word) and opcode 0x23 stores (same funct3 sizes) at rs1 plus immediate. Store data is moved to the lane given by address bits [1:0], with 1, 2 or 4 mask bits set. Load data is moved down by that lane offset. The mask is zero for every non-store.
- R10: `jal` (0x6F) and `jalr` (0x67) write the address of the jump plus 4 to rd. The `jalr` target is rs1 plus the immediate with bit 0 cleared.
- R11: `lui` (0x37) writes the upper immediate, and `auipc` (0x17) writes the execute-stage address plus the upper immediate.
- R12: All immediates are sign-extended from bit 31 in the I, S, B, U and J formats. B and J offsets have bit 0 zero, and U places bits [31:12] over twelve zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Fetch address |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data, already moved to its byte lanes |
| dmem_wmask | output | 4 | Byte-lane write enables, zero when not storing |
| dmem_rdata | input | 32 | Word containing dmem_addr, same cycle |

## Verification
The embedded properties check the pipeline control on every cycle. The fetch address steps by four when nothing redirects, a redirect leaves a zero word in the execute stage, and an untaken branch keeps the fetched word. They also check that the zero word stays inert, that store masks have the right width and stay silent otherwise, and that register 0 stays zero. The operation results cannot be checked cycle by cycle, so the bench runs short programs and stores the registers to memory. These programs cover the arithmetic and multiply results, each branch condition, the lane placement of partial loads and stores, the jump link values and the suppression of the instruction behind a redirect.

// File: rtl/rv2_pkg.sv
package rv2_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned LANES = XLEN / 8;

    localparam logic [6:0] OPC_OPIMM  = 7'h13;
    localparam logic [6:0] OPC_OP     = 7'h33;
    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_STORE  = 7'h23;
    localparam logic [6:0] OPC_JAL    = 7'h6F;
    localparam logic [6:0] OPC_JALR   = 7'h67;
    localparam logic [6:0] OPC_AUIPC  = 7'h17;
    localparam logic [6:0] OPC_LUI    = 7'h37;

    localparam logic [XLEN-1:0] NOP_WORD = '0;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_XOR, ALU_SRL, ALU_SRA,
        ALU_OR, ALU_AND, ALU_MUL, ALU_MULH, ALU_MULHU, ALU_PASSB
    } alu_op_e;

    typedef enum logic [2:0] { IMM_I, IMM_S, IMM_B, IMM_U, IMM_J } imm_kind_e;

    typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_src_e;

    typedef struct packed {
        logic      reg_we;
        logic      a_is_pc;
        logic      b_is_imm;
        alu_op_e   alu_op;
        imm_kind_e imm_kind;
        wb_src_e   wb_src;
        logic      is_load;
        logic      is_store;
        logic      is_branch;
        logic      is_jal;
        logic      is_jalr;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc_f;
        logic [XLEN-1:0] pc_x;
        logic [XLEN-1:0] instr_x;
    } pipe_t;

endpackage

// File: rtl/rv2_regfile.sv
module rv2_regfile #(
    parameter int unsigned NREG  = 32,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] regs_d [NREG];
    logic [WIDTH-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we && waddr != '0) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a == '0) |-> (rdata_a == '0)); // R5
    AST_ZERO_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (regs_q[0] == '0)); // R5

endmodule

// File: rtl/rv2_decode.sv
module rv2_decode
    import rv2_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl,
    output logic [XLEN-1:0] imm,
    output logic [4:0]      rd,
    output logic [4:0]      rs1,
    output logic [4:0]      rs2,
    output logic [2:0]      funct3
);

    logic [6:0] opcode;
    logic [6:0] funct7;

    assign opcode = instr[6:0];
    assign rd     = instr[11:7];
    assign funct3 = instr[14:12];
    assign rs1    = instr[19:15];
    assign rs2    = instr[24:20];
    assign funct7 = instr[31:25];

    always_comb begin
        ctrl          = '0;
        ctrl.alu_op   = ALU_ADD;
        ctrl.imm_kind = IMM_I;
        ctrl.wb_src   = WB_ALU;
        unique case (opcode)
            OPC_OPIMM: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                case (funct3)
                    3'd1:    ctrl.alu_op = ALU_SLL;
                    3'd2:    ctrl.alu_op = ALU_SLT;
                    3'd4:    ctrl.alu_op = ALU_XOR;
                    3'd5:    ctrl.alu_op = instr[30] ? ALU_SRA : ALU_SRL;
                    3'd6:    ctrl.alu_op = ALU_OR;
                    3'd7:    ctrl.alu_op = ALU_AND;
                    default: ctrl.alu_op = ALU_ADD;
                endcase
            end
            OPC_OP: begin
                ctrl.reg_we = 1'b1;
                if (funct7 == 7'h01) begin
                    case (funct3)
                        3'd1:    ctrl.alu_op = ALU_MULH;
                        3'd3:    ctrl.alu_op = ALU_MULHU;
                        default: ctrl.alu_op = ALU_MUL;
                    endcase
                end else begin
                    case (funct3)
                        3'd0:    ctrl.alu_op = instr[30] ? ALU_SUB : ALU_ADD;
                        3'd1:    ctrl.alu_op = ALU_SLL;
                        3'd2:    ctrl.alu_op = ALU_SLT;
                        3'd4:    ctrl.alu_op = ALU_XOR;
                        3'd5:    ctrl.alu_op = instr[30] ? ALU_SRA : ALU_SRL;
                        3'd6:    ctrl.alu_op = ALU_OR;
                        default: ctrl.alu_op = ALU_AND;
                    endcase
                end
            end
            OPC_LOAD: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.wb_src   = WB_MEM;
                ctrl.is_load  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.imm_kind = IMM_S;
                ctrl.is_store = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl.imm_kind  = IMM_B;
                ctrl.is_branch = 1'b1;
            end
            OPC_JAL: begin
                ctrl.reg_we   = 1'b1;
                ctrl.imm_kind = IMM_J;
                ctrl.wb_src   = WB_LINK;
                ctrl.is_jal   = 1'b1;
            end
            OPC_JALR: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.wb_src   = WB_LINK;
                ctrl.is_jalr  = 1'b1;
            end
            OPC_AUIPC: begin
                ctrl.reg_we   = 1'b1;
                ctrl.a_is_pc  = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.imm_kind = IMM_U;
            end
            OPC_LUI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.imm_kind = IMM_U;
                ctrl.alu_op   = ALU_PASSB;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (ctrl.imm_kind)
            IMM_S:   imm = {{21{instr[31]}}, instr[30:25], instr[11:7]};
            IMM_B:   imm = {{20{instr[31]}}, instr[7], instr[30:25], instr[11:8], 1'b0};
            IMM_U:   imm = {instr[31:12], 12'b0};
            IMM_J:   imm = {{12{instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
            default: imm = {{21{instr[31]}}, instr[30:20]};
        endcase
    end

endmodule

// File: rtl/rv2_exec.sv
module rv2_exec
    import rv2_pkg::*;
(
    input  alu_op_e         alu_op,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] cmp_a,
    input  logic [XLEN-1:0] cmp_b,
    input  logic [2:0]      br_kind,
    output logic [XLEN-1:0] result,
    output logic            br_taken
);

    localparam int unsigned SHW = $clog2(XLEN);

    logic [SHW-1:0]    shamt;
    logic              mul_signed;
    logic [2*XLEN-1:0] prod;
    logic              cmp_eq;
    logic              cmp_lt;

    assign shamt      = op_b[SHW-1:0];
    assign mul_signed = (alu_op != ALU_MULHU);
    assign prod = {{XLEN{op_a[XLEN-1] & mul_signed}}, op_a}
                * {{XLEN{op_b[XLEN-1] & mul_signed}}, op_b};

    always_comb begin
        unique case (alu_op)
            ALU_SUB:   result = op_a - op_b;
            ALU_SLL:   result = op_a << shamt;
            ALU_SLT:   result = {{(XLEN-1){1'b0}}, $signed(op_a) < $signed(op_b)};
            ALU_XOR:   result = op_a ^ op_b;
            ALU_SRL:   result = op_a >> shamt;
            ALU_SRA:   result = $unsigned($signed(op_a) >>> shamt);
            ALU_OR:    result = op_a | op_b;
            ALU_AND:   result = op_a & op_b;
            ALU_MUL:   result = prod[XLEN-1:0];
            ALU_MULH,
            ALU_MULHU: result = prod[2*XLEN-1:XLEN];
            ALU_PASSB: result = op_b;
            default:   result = op_a + op_b;
        endcase
    end

    // branch comparator: funct3 bit 1 picks unsigned compare
    assign cmp_eq = (cmp_a == cmp_b);
    assign cmp_lt = br_kind[1] ? (cmp_a < cmp_b) : ($signed(cmp_a) < $signed(cmp_b));

    always_comb begin
        case (br_kind)
            3'd0:       br_taken = cmp_eq;
            3'd1:       br_taken = !cmp_eq;
            3'd4, 3'd6: br_taken = cmp_lt;
            3'd5, 3'd7: br_taken = !cmp_lt;
            default:    br_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/rv2_core.sv
module rv2_core
    import rv2_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic [3:0]  dmem_wmask,
    input  logic [31:0] dmem_rdata
);

    localparam int unsigned NREG = 32;
    localparam int unsigned OFSW = $clog2(LANES);

    pipe_t cur_q, nxt_d;

    ctrl_t           ctrl;
    logic [XLEN-1:0] imm;
    logic [4:0]      rd, rs1, rs2;
    logic [2:0]      funct3;
    logic [XLEN-1:0] rs1_val, rs2_val;
    logic [XLEN-1:0] op_a, op_b, alu_res;
    logic            br_taken;
    logic            redirect;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] link;
    logic [OFSW-1:0] lane;
    logic [XLEN-1:0] ld_shifted, ld_val, wb_val;
    logic [LANES-1:0] st_mask;

    rv2_decode u_decode (
        .instr  (cur_q.instr_x),
        .ctrl   (ctrl),
        .imm    (imm),
        .rd     (rd),
        .rs1    (rs1),
        .rs2    (rs2),
        .funct3 (funct3)
    );

    rv2_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl.reg_we),
        .waddr   (rd),
        .wdata   (wb_val),
        .raddr_a (rs1),
        .raddr_b (rs2),
        .rdata_a (rs1_val),
        .rdata_b (rs2_val)
    );

    assign op_a = ctrl.a_is_pc  ? cur_q.pc_x : rs1_val;
    assign op_b = ctrl.b_is_imm ? imm        : rs2_val;

    rv2_exec u_exec (
        .alu_op   (ctrl.alu_op),
        .op_a     (op_a),
        .op_b     (op_b),
        .cmp_a    (rs1_val),
        .cmp_b    (rs2_val),
        .br_kind  (funct3),
        .result   (alu_res),
        .br_taken (br_taken)
    );

    // redirect resolution, all relative to the execute-stage address
    assign redirect = ctrl.is_jal || ctrl.is_jalr || (ctrl.is_branch && br_taken);
    assign target   = ctrl.is_jalr ? {alu_res[XLEN-1:1], 1'b0} : (cur_q.pc_x + imm);
    assign link     = cur_q.pc_x + XLEN'(4);

    // data memory lanes
    assign lane = alu_res[OFSW-1:0];

    always_comb begin
        case (funct3[1:0])
            2'd0:    st_mask = LANES'(1) << lane;
            2'd1:    st_mask = LANES'(3) << lane;
            default: st_mask = '1;
        endcase
    end

    assign dmem_addr  = alu_res;
    assign dmem_wdata = rs2_val << {lane, 3'b000};
    assign dmem_wmask = ctrl.is_store ? st_mask : '0;
    assign ld_shifted = dmem_rdata >> {lane, 3'b000};

    always_comb begin
        case (funct3[1:0])
            2'd0:    ld_val = {{(XLEN-8){ld_shifted[7]}}, ld_shifted[7:0]};
            2'd1:    ld_val = {{(XLEN-16){ld_shifted[15]}}, ld_shifted[15:0]};
            default: ld_val = ld_shifted;
        endcase
    end

    always_comb begin
        unique case (ctrl.wb_src)
            WB_MEM:  wb_val = ld_val;
            WB_LINK: wb_val = link;
            default: wb_val = alu_res;
        endcase
    end

    // next-state of the fetch/execute boundary
    always_comb begin
        nxt_d         = cur_q;
        nxt_d.pc_x    = cur_q.pc_f;
        nxt_d.instr_x = redirect ? NOP_WORD : imem_data;
        nxt_d.pc_f    = redirect ? target : (cur_q.pc_f + XLEN'(4));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.pc_f    <= RESET_PC;
            cur_q.pc_x    <= RESET_PC;
            cur_q.instr_x <= NOP_WORD;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign imem_addr = cur_q.pc_f;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> (cur_q.pc_f == $past(cur_q.pc_f) + 32'd4)); // R1
    AST_FLUSH_TO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (cur_q.instr_x == NOP_WORD)); // R2
    AST_UNTAKEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.is_branch && !redirect) |=> (cur_q.instr_x == $past(imem_data))); // R3
    AST_NOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.instr_x == NOP_WORD) |-> (dmem_wmask == '0 && !redirect)); // R4
    AST_JALR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.is_jalr |=> (cur_q.pc_f[0] == 1'b0)); // R10
    AST_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.is_store && funct3 == 3'd0) |-> ($countones(dmem_wmask) == 1)); // R9
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.is_store |-> (dmem_wmask == '0)); // R9

endmodule

// File: tb/rv2_core_bench.sv
`timescale 1ns/1ps
module rv2_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0]  dmem_wmask;

    logic [31:0] rom [64];
    logic [31:0] ram [256];
    logic        ram_clr = 1'b1;
    int          store_cycles = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    int          wp = 0;

    always #2.5 clk = ~clk;

    rv2_core u_rv2_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_wmask (dmem_wmask),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = rom[imem_addr[7:2]];
    assign dmem_rdata = ram[dmem_addr[9:2]];

    always_ff @(posedge clk) begin
        if (ram_clr) begin
            for (int i = 0; i < 256; i++) ram[i] <= '0;
            store_cycles <= 0;
        end else begin
            for (int b = 0; b < 4; b++)
                if (dmem_wmask[b]) ram[dmem_addr[9:2]][8*b +: 8] <= dmem_wdata[8*b +: 8];
            if (dmem_wmask != '0) store_cycles <= store_cycles + 1;
        end
    end

    // ---- instruction encoders ----
    function automatic logic [31:0] e_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
        logic [31:0] v = imm;
        return {v[11:0], 5'(rs1), 3'(f3), 5'(rd), op};
    endfunction
    function automatic logic [31:0] e_r(int f7, int rs2, int rs1, int f3, int rd);
        return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'h33};
    endfunction
    function automatic logic [31:0] e_s(int imm, int rs2, int rs1, int f3);
        logic [31:0] v = imm;
        return {v[11:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] e_b(int imm, int rs2, int rs1, int f3);
        logic [31:0] v = imm;
        return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:1], v[11], 7'h63};
    endfunction
    function automatic logic [31:0] e_u(int imm20, int rd, logic [6:0] op);
        logic [31:0] v = imm20;
        return {v[19:0], 5'(rd), op};
    endfunction
    function automatic logic [31:0] e_j(int imm, int rd);
        logic [31:0] v = imm;
        return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'h6F};
    endfunction

    task automatic put(logic [31:0] w);
        rom[wp] = w;
        wp++;
    endtask

    task automatic new_prog();
        for (int i = 0; i < 64; i++) rom[i] = '0;
        wp = 0;
    endtask

    task automatic dump_regs(int first, int count);
        for (int k = 0; k < count; k++) put(e_s(4 * k, first + k, 0, 2));
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        ram_clr = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ram_clr = 1'b0;
        rst_n   = 1'b1;
    endtask

    task automatic run(int cycles);
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_mem(string req, int idx, logic [31:0] exp);
        chk(req, ram[idx], exp);
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        new_prog();
        rst_n   = 1'b0;
        ram_clr = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4 fetch address in reset", imem_addr, 32'h0);
        chk("R4 no store in reset", {28'b0, dmem_wmask}, 32'h0);
        ram_clr = 1'b0;
        rst_n   = 1'b1;
        run(1);
        chk("R1 pc after first edge", imem_addr, 32'd4);
        run(2);
        chk("R1 pc after three edges", imem_addr, 32'd12);
        run(20);
        chk("R4 zero words store nothing", store_cycles, 32'd0);
    endtask

    task automatic t_imm_ops();
        new_prog();
        put(e_i(-5, 0, 0, 1, 7'h13));      // addi x1,x0,-5
        put(e_i('h0F0, 1, 7, 2, 7'h13));   // andi
        put(e_i('h123, 0, 6, 3, 7'h13));   // ori
        put(e_i(-1, 1, 4, 4, 7'h13));      // xori
        put(e_i(4, 3, 1, 5, 7'h13));       // slli
        put(e_i(28, 1, 5, 6, 7'h13));      // srli
        put(e_i('h401, 1, 5, 7, 7'h13));   // srai by 1
        put(e_i(-4, 1, 2, 8, 7'h13));      // slti
        put(e_i(7, 0, 0, 0, 7'h13));       // addi x0 (dropped)
        for (int k = 0; k < 9; k++) put(e_s(4 * k, (k == 8) ? 0 : k + 1, 0, 2));
        put(e_j(0, 0));
        do_reset();
        run(40);
        chk_mem("R12 addi negative imm", 0, 32'hFFFF_FFFB);
        chk_mem("R6 andi", 1, 32'h0000_00F0);
        chk_mem("R6 ori", 2, 32'h0000_0123);
        chk_mem("R6 xori", 3, 32'h0000_0004);
        chk_mem("R6 slli", 4, 32'h0000_1230);
        chk_mem("R6 srli", 5, 32'h0000_000F);
        chk_mem("R6 srai", 6, 32'hFFFF_FFFD);
        chk_mem("R6 slti", 7, 32'h0000_0001);
        chk_mem("R5 write to x0 dropped", 8, 32'h0);
    endtask

    task automatic t_reg_ops();
        new_prog();
        put(e_i(-7, 0, 0, 1, 7'h13));
        put(e_i(3, 0, 0, 2, 7'h13));
        put(e_u('h80000, 3, 7'h37));
        put(e_r(0, 2, 1, 0, 4));       // add
        put(e_r('h20, 1, 2, 0, 5));    // sub x2-x1
        put(e_r('h20, 2, 1, 5, 6));    // sra
        put(e_r(0, 2, 1, 5, 7));       // srl
        put(e_r(1, 2, 1, 0, 8));       // mul
        put(e_r(1, 2, 1, 1, 9));       // mulh
        put(e_r(1, 2, 1, 3, 10));      // mulhu
        put(e_r(0, 2, 1, 2, 11));      // slt
        put(e_r(0, 2, 1, 4, 12));      // xor
        put(e_r(0, 2, 2, 1, 13));      // sll
        put(e_r(0, 2, 1, 7, 14));      // and
        put(e_r(0, 2, 1, 6, 15));      // or
        put(e_r(1, 2, 3, 1, 16));      // mulh x3*x2
        put(e_r(1, 2, 3, 3, 17));      // mulhu x3*x2
        dump_regs(4, 14);
        put(e_j(0, 0));
        do_reset();
        run(60);
        chk_mem("R7 add", 0, 32'hFFFF_FFFC);
        chk_mem("R7 sub", 1, 32'd10);
        chk_mem("R7 sra", 2, 32'hFFFF_FFFF);
        chk_mem("R7 srl", 3, 32'h1FFF_FFFF);
        chk_mem("R7 mul", 4, 32'hFFFF_FFEB);
        chk_mem("R7 mulh", 5, 32'hFFFF_FFFF);
        chk_mem("R7 mulhu", 6, 32'h0000_0002);
        chk_mem("R7 slt", 7, 32'h1);
        chk_mem("R7 xor", 8, 32'hFFFF_FFFA);
        chk_mem("R7 sll", 9, 32'h18);
        chk_mem("R7 and", 10, 32'h1);
        chk_mem("R7 or", 11, 32'hFFFF_FFFB);
        chk_mem("R7 mulh min-int", 12, 32'hFFFF_FFFE);
        chk_mem("R7 mulhu min-int", 13, 32'h1);
    endtask

    task automatic t_branches();
        new_prog();
        put(e_i(5, 0, 0, 1, 7'h13));        // 0
        put(e_i(-3, 0, 0, 2, 7'h13));       // 1
        put(e_i(0, 0, 0, 10, 7'h13));       // 2
        put(e_b(8, 1, 1, 0));               // 3 beq taken
        put(e_i(1, 10, 0, 10, 7'h13));      // 4 flushed
        put(e_b(8, 1, 1, 1));               // 5 bne not taken
        put(e_i(2, 10, 0, 10, 7'h13));      // 6
        put(e_b(8, 1, 2, 4));               // 7 blt taken
        put(e_i(4, 10, 0, 10, 7'h13));      // 8 flushed
        put(e_b(8, 1, 2, 6));               // 9 bltu not taken
        put(e_i(8, 10, 0, 10, 7'h13));      // 10
        put(e_b(8, 2, 1, 5));               // 11 bge taken
        put(e_i(16, 10, 0, 10, 7'h13));     // 12 flushed
        put(e_b(8, 2, 1, 7));               // 13 bgeu not taken
        put(e_i(32, 10, 0, 10, 7'h13));     // 14
        put(e_b(8, 2, 1, 0));               // 15 beq not taken
        put(e_i(64, 10, 0, 10, 7'h13));     // 16
        put(e_b(12, 2, 1, 1));              // 17 bne taken
        put(e_i(128, 10, 0, 10, 7'h13));    // 18 flushed
        put(e_i(256, 10, 0, 10, 7'h13));    // 19 skipped
        put(e_b(8, 2, 1, 4));               // 20 blt not taken
        put(e_i(512, 10, 0, 10, 7'h13));    // 21
        put(e_i(3, 0, 0, 11, 7'h13));       // 22
        put(e_i(1, 12, 0, 12, 7'h13));      // 23 loop body
        put(e_i(-1, 11, 0, 11, 7'h13));     // 24
        put(e_b(-8, 0, 11, 1));             // 25 bne back
        put(e_i(100, 12, 0, 12, 7'h13));    // 26
        put(e_s(0, 10, 0, 2));
        put(e_s(4, 12, 0, 2));
        put(e_j(0, 0));
        do_reset();
        run(80);
        chk_mem("R8 R2 R3 branch accumulator", 0, 32'd618);
        chk_mem("R2 R12 backward loop flush", 1, 32'd103);
    endtask

    task automatic t_memory();
        new_prog();
        put(e_u('h12345, 1, 7'h37));
        put(e_i('h678, 1, 0, 1, 7'h13));
        put(e_i('h100, 0, 0, 2, 7'h13));
        put(e_s(0, 1, 2, 2));       // sw
        put(e_s(-4, 1, 2, 2));      // sw negative offset
        put(e_s(5, 1, 2, 0));       // sb lane 1
        put(e_s(10, 1, 2, 1));      // sh upper half
        put(e_i(-1, 0, 0, 3, 7'h13));
        put(e_s(12, 3, 2, 1));      // sh lower half
        put(e_s(19, 3, 2, 0));      // sb lane 3
        put(e_i(3, 2, 0, 4, 7'h03));   // lb
        put(e_i(19, 2, 0, 5, 7'h03));  // lb negative
        put(e_i(12, 2, 1, 6, 7'h03));  // lh negative
        put(e_i(2, 2, 1, 7, 7'h03));   // lh upper
        put(e_i(8, 2, 2, 8, 7'h03));   // lw
        put(e_i(1, 2, 0, 9, 7'h03));   // lb lane 1
        dump_regs(4, 6);
        put(e_j(0, 0));
        do_reset();
        run(50);
        chk_mem("R9 sw", 64, 32'h1234_5678);
        chk_mem("R9 R12 sw negative offset", 63, 32'h1234_5678);
        chk_mem("R9 sb lane 1", 65, 32'h0000_7800);
        chk_mem("R9 sh upper half", 66, 32'h5678_0000);
        chk_mem("R9 sh lower half", 67, 32'h0000_FFFF);
        chk_mem("R9 sb lane 3", 68, 32'hFF00_0000);
        chk_mem("R9 lb positive", 0, 32'h0000_0012);
        chk_mem("R9 lb sign", 1, 32'hFFFF_FFFF);
        chk_mem("R9 lh sign", 2, 32'hFFFF_FFFF);
        chk_mem("R9 lh upper", 3, 32'h0000_1234);
        chk_mem("R9 lw", 4, 32'h5678_0000);
        chk_mem("R9 lb lane 1", 5, 32'h0000_0056);
    endtask

    task automatic t_jumps();
        new_prog();
        put(e_u(1, 1, 7'h17));               // 0 auipc
        put(e_u('hFFFFF, 2, 7'h37));         // 4 lui
        put(e_j(12, 3));                     // 8 jal -> 20
        put(e_i(1, 10, 0, 10, 7'h13));       // 12 flushed
        put(e_i(2, 10, 0, 10, 7'h13));       // 16 skipped
        put(e_i(33, 0, 0, 4, 7'h13));        // 20
        put(e_i(0, 4, 0, 5, 7'h67));         // 24 jalr -> 32
        put(e_i(4, 10, 0, 10, 7'h13));       // 28 flushed
        put(e_u(0, 6, 7'h17));               // 32 auipc
        put(e_s(0, 1, 0, 2));
        put(e_s(4, 2, 0, 2));
        put(e_s(8, 3, 0, 2));
        put(e_s(12, 5, 0, 2));
        put(e_s(16, 6, 0, 2));
        put(e_s(20, 10, 0, 2));
        put(e_j(0, 0));
        do_reset();
        run(40);
        chk_mem("R11 auipc", 0, 32'h0000_1000);
        chk_mem("R11 lui", 1, 32'hFFFF_F000);
        chk_mem("R10 jal link", 2, 32'd12);
        chk_mem("R10 jalr link", 3, 32'd28);
        chk_mem("R10 R11 jalr bit0 cleared, auipc at target", 4, 32'd32);
        chk_mem("R2 jump shadow suppressed", 5, 32'd0);
    endtask

    initial begin
        #500000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_imm_ops();
        t_reg_ops();
        t_branches();
        t_memory();
        t_jumps();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule